// File: doc/BRIEF.md
# Processor Status Register Unit

This block keeps the 128-bit machine status word for a mainframe-style core. It holds the condition code, the program mask, the storage key, the privilege and wait flags, the interrupt enable masks, the address-space selector, the addressing-mode bits and the instruction address. Bit numbering starts at 0 on the most significant (leftmost) bit. Internally the word is always kept in the 128-bit long layout.

Privileged software replaces the word through a load port that accepts either a 64-bit compact word or a 128-bit full word. The load is checked before it takes effect. If the loaded bits are illegal, the register keeps its old value and a specification-error pulse is raised. If the core is in problem state, the load is refused and a privileged-operation pulse is raised.

Unprivileged logic can change only the condition code and the program mask. The branch unit asks whether a 4-bit branch mask matches the current condition code. The fetch path advances the instruction address by 2, 4 or 6 bytes, and the sum wraps according to the current addressing mode. An extract port returns the word in compact form, or in full form when 64-bit addressing is active.

Top module: `psw_unit`

## Requirements
- R1: After reset, every bit of the stored word is 0. This gives supervisor state, 24-bit mode, condition code 0 and instruction address 0. Both error outputs are low.
- R2: `br_taken` is bit (3 - cc) of `br_mask`. Mask weight 8 tests code 0, weight 4 tests code 1, weight 2 tests code 2 and weight 1 tests code 3. The output is combinational.
- R3: A compact load (`ld_long`=0) takes its 64 bits from `ld_word[127:64]`, and bit 12 of that word must be 1. Bits 0-32 are copied into bits 0-32 of the stored word, except that stored bit 12 is 0. Compact bits 33-63 become the low 31 address bits, and the upper 33 address bits are cleared.
- R4: A full load (`ld_long`=1) requires bit 12 to be 0. The stored word then equals `ld_word`, with the instruction address in bits 64-127.
- R5: A load is rejected if bit 12 has the wrong value for its format. It is also rejected if any of bits 0, 2-4 or 24-30 is set, if a full load has any of bits 33-63 set, or if bit 31 and bit 32 are both 1. On a rejected load the stored word is unchanged and `spec_err` is high for exactly the next cycle.
- R6: A load issued while problem state (bit 15) is 1 is ignored, whatever its content. `priv_err` is then high for the next cycle, and `spec_err` stays low.
- R7: The unprivileged set port writes only the condition code (bits 18-19) and the program mask (bits 20-23), in any state. When `ld_en` is high in the same cycle, both the set port and the advance port are ignored.
- R8: `amode` is 2 (64-bit) when bit 31 is 1. Otherwise it is 1 (31-bit) when bit 32 is 1, and 0 (24-bit) when both are 0.
- R9: When `adv_en` is high, `adv_len` values 0, 1, 2 and 3 add 0, 2, 4 and 6 bytes to the address. The result wraps modulo 2^24, 2^31 or 2^64 according to `amode`.
- R10: In 24-bit or 31-bit mode, `ext_word[127:64]` holds the compact form: bits 0-32 of the stored word with bit 12 forced to 1, and the low 31 address bits in bits 33-63. In that case `ext_word[63:0]` is 0 and `ext_is_long` is 0. In 64-bit mode, `ext_word` is the stored word and `ext_is_long` is 1.
- R11: The field outputs report the stored bits: key from bits 8-11, address space from bits 16-17, I/O mask from bit 6, problem state from bit 15 and program mask from bits 20-23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Privileged load request |
| ld_long | input | 1 | 1 = full 128-bit format, 0 = compact format in upper half |
| ld_word | input | 128 | Word to load |
| set_en | input | 1 | Unprivileged condition-code and program-mask write |
| set_cc | input | 2 | New condition code |
| set_pm | input | 4 | New program mask |
| adv_en | input | 1 | Advance instruction address |
| adv_len | input | 2 | Advance amount in halfwords (0-3) |
| br_mask | input | 4 | Branch mask to test |
| br_taken | output | 1 | Mask selects the current condition code |
| spec_err | output | 1 | Rejected load, specification error |
| priv_err | output | 1 | Rejected load, privileged operation |
| cc | output | 2 | Condition code |
| prog_mask | output | 4 | Program mask |
| key | output | 4 | Storage key |
| addr_space | output | 2 | Address-space selector |
| problem_st | output | 1 | Problem state |
| wait_st | output | 1 | Wait state |
| per_mask | output | 1 | Event-recording mask |
| dat_mode | output | 1 | Translation mode |
| io_mask | output | 1 | I/O interrupt mask |
| ext_mask | output | 1 | External interrupt mask |
| mchk_mask | output | 1 | Machine-check mask |
| amode | output | 2 | Addressing mode: 0=24, 1=31, 2=64 |
| instr_addr | output | 64 | Instruction address |
| psw_out | output | 128 | Stored word, full layout |
| ext_word | output | 128 | Extracted word |
| ext_is_long | output | 1 | Extracted word is in full layout |

## Verification
The privileged-operation path is the hardest to reach, because the only way into problem state is a legal load that itself sets bit 15. After that, every further load must be refused. The bench first loads a legal full word with the problem bit set. It then offers both a legal word and an illegal word, which shows that the privilege refusal takes precedence over the specification check. It checks that the set port still works in that state, and it recovers through reset. Address wrap at each mode boundary is reached by loading addresses a few bytes below 2^24, 2^31 and 2^64 and then advancing by 2 or 6 bytes.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W   = 128;
  localparam int SHORT_W = 64;
  localparam int IA_W    = 64;
  localparam int HDR_W   = 33;               // bits 0..32 shared by both layouts
  localparam int SA_W    = SHORT_W - HDR_W;  // compact address width (31)
  localparam int A24_W   = 24;
  localparam int A31_W   = 31;
  localparam int CC_N    = 4;

  // Leftmost-bit-0 positions mapped to vector indices of the full layout
  localparam int P_PER   = PSW_W - 1 - 1;
  localparam int P_DAT   = PSW_W - 1 - 5;
  localparam int P_IO    = PSW_W - 1 - 6;
  localparam int P_EXT   = PSW_W - 1 - 7;
  localparam int P_KEYH  = PSW_W - 1 - 8;
  localparam int P_KEYL  = PSW_W - 1 - 11;
  localparam int P_FMT   = PSW_W - 1 - 12;
  localparam int P_MCHK  = PSW_W - 1 - 13;
  localparam int P_WAIT  = PSW_W - 1 - 14;
  localparam int P_PROB  = PSW_W - 1 - 15;
  localparam int P_ASH   = PSW_W - 1 - 16;
  localparam int P_ASL   = PSW_W - 1 - 17;
  localparam int P_CCH   = PSW_W - 1 - 18;
  localparam int P_CCL   = PSW_W - 1 - 19;
  localparam int P_PMH   = PSW_W - 1 - 20;
  localparam int P_PML   = PSW_W - 1 - 23;
  localparam int P_EA    = PSW_W - 1 - 31;
  localparam int P_BA    = PSW_W - 1 - 32;

  // Same positions inside the 33-bit header
  localparam int H_R0    = HDR_W - 1 - 0;
  localparam int H_R2    = HDR_W - 1 - 2;
  localparam int H_R4    = HDR_W - 1 - 4;
  localparam int H_FMT   = HDR_W - 1 - 12;
  localparam int H_R24   = HDR_W - 1 - 24;
  localparam int H_R30   = HDR_W - 1 - 30;
  localparam int H_EA    = HDR_W - 1 - 31;
  localparam int H_BA    = HDR_W - 1 - 32;

  typedef enum logic [1:0] {
    AM_24 = 2'd0,
    AM_31 = 2'd1,
    AM_64 = 2'd2
  } amode_e;
endpackage

// File: rtl/psw_load_check.sv
module psw_load_check
  import psw_pkg::*;
(
  input  logic             fmt_long,
  input  logic [PSW_W-1:0] word,
  output logic             legal,
  output logic [PSW_W-1:0] image
);
  logic [SHORT_W-1:0] sw;
  logic [HDR_W-1:0]   hdr;
  logic [PSW_W-1:0]   img_s;
  logic               fmt_ok, res_ok, mode_ok, tail_ok;

  assign sw  = word[PSW_W-1 -: SHORT_W];
  assign hdr = fmt_long ? word[PSW_W-1 -: HDR_W] : sw[SHORT_W-1 -: HDR_W];

  always_comb begin
    img_s = '0;
    img_s[PSW_W-1 -: HDR_W] = sw[SHORT_W-1 -: HDR_W];
    img_s[P_FMT] = 1'b0;
    img_s[SA_W-1:0] = sw[SA_W-1:0];
  end

  assign fmt_ok  = fmt_long ? ~hdr[H_FMT] : hdr[H_FMT];
  assign res_ok  = ~hdr[H_R0] && (hdr[H_R2:H_R4] == '0) && (hdr[H_R24:H_R30] == '0);
  assign tail_ok = ~fmt_long || (word[PSW_W-1-HDR_W -: SA_W] == '0);
  assign mode_ok = ~(hdr[H_EA] & hdr[H_BA]);
  assign legal   = fmt_ok & res_ok & tail_ok & mode_ok;
  assign image   = fmt_long ? word : img_s;
endmodule

// File: rtl/psw_branch_eval.sv
module psw_branch_eval
  import psw_pkg::*;
(
  input  logic [1:0]      cc,
  input  logic [CC_N-1:0] mask,
  output logic            taken
);
  logic [1:0] idx;
  assign idx   = 2'(CC_N - 1) - cc;  // weight 8 selects code 0
  assign taken = mask[idx];
endmodule

// File: rtl/psw_addr_adv.sv
module psw_addr_adv
  import psw_pkg::*;
(
  input  logic [IA_W-1:0] ia,
  input  logic [1:0]      len,
  input  amode_e          mode,
  output logic [IA_W-1:0] next_ia
);
  logic [IA_W-1:0] sum;
  assign sum = ia + IA_W'({len, 1'b0});

  always_comb begin
    case (mode)
      AM_24:   next_ia = {{(IA_W-A24_W){1'b0}}, sum[A24_W-1:0]};
      AM_31:   next_ia = {{(IA_W-A31_W){1'b0}}, sum[A31_W-1:0]};
      default: next_ia = sum;
    endcase
  end
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic             ld_long,
  input  logic [PSW_W-1:0] ld_word,
  input  logic             set_en,
  input  logic [1:0]       set_cc,
  input  logic [3:0]       set_pm,
  input  logic             adv_en,
  input  logic [1:0]       adv_len,
  input  logic [CC_N-1:0]  br_mask,
  output logic             br_taken,
  output logic             spec_err,
  output logic             priv_err,
  output logic [1:0]       cc,
  output logic [3:0]       prog_mask,
  output logic [3:0]       key,
  output logic [1:0]       addr_space,
  output logic             problem_st,
  output logic             wait_st,
  output logic             per_mask,
  output logic             dat_mode,
  output logic             io_mask,
  output logic             ext_mask,
  output logic             mchk_mask,
  output logic [1:0]       amode,
  output logic [IA_W-1:0]  instr_addr,
  output logic [PSW_W-1:0] psw_out,
  output logic [PSW_W-1:0] ext_word,
  output logic             ext_is_long
);
  logic [PSW_W-1:0] psw_q, psw_d, ld_image;
  logic             ld_legal, psw_ce;
  logic             spec_q, spec_d, priv_q, priv_d;
  logic [IA_W-1:0]  ia_next;
  amode_e           mode;
  logic [SHORT_W-1:0] short_w;

  psw_load_check u_chk (
    .fmt_long (ld_long),
    .word     (ld_word),
    .legal    (ld_legal),
    .image    (ld_image)
  );

  psw_branch_eval u_br (
    .cc    (psw_q[P_CCH:P_CCL]),
    .mask  (br_mask),
    .taken (br_taken)
  );

  psw_addr_adv u_adv (
    .ia      (psw_q[IA_W-1:0]),
    .len     (adv_len),
    .mode    (mode),
    .next_ia (ia_next)
  );

  always_comb begin
    if (psw_q[P_EA])      mode = AM_64;
    else if (psw_q[P_BA]) mode = AM_31;
    else                  mode = AM_24;
  end

  // next-state
  always_comb begin
    psw_d  = psw_q;
    spec_d = 1'b0;
    priv_d = 1'b0;
    if (ld_en) begin
      if (psw_q[P_PROB])  priv_d = 1'b1;
      else if (!ld_legal) spec_d = 1'b1;
      else                psw_d  = ld_image;
    end else begin
      if (set_en) begin
        psw_d[P_CCH:P_CCL] = set_cc;
        psw_d[P_PMH:P_PML] = set_pm;
      end
      if (adv_en) psw_d[IA_W-1:0] = ia_next;
    end
  end

  assign psw_ce = ld_en | set_en | adv_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw_q <= '0;
    end else if (psw_ce) begin
      psw_q <= psw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spec_q <= 1'b0;
      priv_q <= 1'b0;
    end else begin
      spec_q <= spec_d;
      priv_q <= priv_d;
    end
  end

  always_comb begin
    short_w = {psw_q[PSW_W-1 -: HDR_W], psw_q[SA_W-1:0]};
    short_w[P_FMT-(PSW_W-SHORT_W)] = 1'b1;
  end

  assign ext_is_long = (mode == AM_64);
  assign ext_word    = ext_is_long ? psw_q : {short_w, {(PSW_W-SHORT_W){1'b0}}};

  assign spec_err   = spec_q;
  assign priv_err   = priv_q;
  assign cc         = psw_q[P_CCH:P_CCL];
  assign prog_mask  = psw_q[P_PMH:P_PML];
  assign key        = psw_q[P_KEYH:P_KEYL];
  assign addr_space = psw_q[P_ASH:P_ASL];
  assign problem_st = psw_q[P_PROB];
  assign wait_st    = psw_q[P_WAIT];
  assign per_mask   = psw_q[P_PER];
  assign dat_mode   = psw_q[P_DAT];
  assign io_mask    = psw_q[P_IO];
  assign ext_mask   = psw_q[P_EXT];
  assign mchk_mask  = psw_q[P_MCHK];
  assign amode      = mode;
  assign instr_addr = psw_q[IA_W-1:0];
  assign psw_out    = psw_q;
endmodule

// File: rtl/psw_unit_chk.sv
module psw_unit_chk
  import psw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ld_en,
  input logic             set_en,
  input logic             adv_en,
  input logic             problem_st,
  input logic             spec_err,
  input logic             priv_err,
  input logic [1:0]       amode,
  input logic [1:0]       cc,
  input logic [CC_N-1:0]  br_mask,
  input logic             br_taken,
  input logic [IA_W-1:0]  instr_addr,
  input logic [PSW_W-1:0] psw_out,
  input logic             ext_is_long
);
  a_r6_priv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && problem_st |=> priv_err && !spec_err && $stable(psw_out));

  a_r5_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(spec_err && priv_err));

  a_r5_spec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    spec_err |-> $stable(psw_out));

  a_r8_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    amode != 2'd3);

  a_r7_set_scope: assert property (@(posedge clk) disable iff (!rst_n)
    set_en && !ld_en |=> (psw_out[PSW_W-1:P_ASL] == $past(psw_out[PSW_W-1:P_ASL]))
                      && (psw_out[P_PML-1:IA_W] == $past(psw_out[P_PML-1:IA_W])));

  a_r10_ext_fmt: assert property (@(posedge clk) disable iff (!rst_n)
    ext_is_long == (amode == 2'd2));

  a_r9_wrap24: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en && !ld_en && amode == 2'd0 |=> instr_addr[IA_W-1:A24_W] == '0);

  a_r2_code0: assert property (@(posedge clk) disable iff (!rst_n)
    cc == 2'd0 && br_mask[3] |-> br_taken);

  a_r2_empty: assert property (@(posedge clk) disable iff (!rst_n)
    br_mask == '0 |-> !br_taken);
endmodule

bind psw_unit psw_unit_chk chk_i (.*);

// File: tb/psw_unit_tb_top.sv
module psw_unit_tb_top;
  logic         clk, rst_n;
  logic         ld_en, ld_long, set_en, adv_en;
  logic [127:0] ld_word;
  logic [1:0]   set_cc, adv_len;
  logic [3:0]   set_pm, br_mask;
  logic         br_taken, spec_err, priv_err, problem_st, wait_st;
  logic         per_mask, dat_mode, io_mask, ext_mask, mchk_mask, ext_is_long;
  logic [1:0]   cc, addr_space, amode;
  logic [3:0]   prog_mask, key;
  logic [63:0]  instr_addr;
  logic [127:0] psw_out, ext_word;
  int errors = 0, checks = 0;
  bit done = 0;

  psw_unit dut_i (.*);

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic tick; @(posedge clk); #1; endtask

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_long(logic [3:0] k, logic [1:0] as, logic [1:0] c,
      logic [3:0] pm, logic prob, logic ea, logic ba, logic io, logic [63:0] ia);
    logic [127:0] w = '0;
    w[127-6] = io; w[127-8 -: 4] = k; w[127-15] = prob; w[127-16 -: 2] = as;
    w[127-18 -: 2] = c; w[127-20 -: 4] = pm; w[127-31] = ea; w[127-32] = ba;
    w[63:0] = ia;
    return w;
  endfunction

  function automatic logic [127:0] mk_short(logic [3:0] k, logic [1:0] c, logic ba, logic [30:0] ia);
    logic [63:0] s = '0;
    s[63-8 -: 4] = k; s[63-12] = 1'b1; s[63-18 -: 2] = c; s[63-32] = ba; s[30:0] = ia;
    return {s, 64'h0};
  endfunction

  task automatic do_reset;
    rst_n = 0; ld_en = 0; ld_long = 0; ld_word = '0; set_en = 0; set_cc = 0;
    set_pm = 0; adv_en = 0; adv_len = 0; br_mask = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1; tick();
  endtask

  task automatic load(logic fmt, logic [127:0] w);
    ld_en = 1; ld_long = fmt; ld_word = w; tick(); ld_en = 0;
  endtask

  task automatic advance(logic [1:0] n);
    adv_en = 1; adv_len = n; tick(); adv_en = 0;
  endtask

  task automatic t_reset;
    check("R1 word", psw_out, '0);
    check("R1 errs", {spec_err, priv_err}, 0);
    check("R10 ext at reset", ext_word, {64'h0008_0000_0000_0000, 64'h0});
    check("R8 mode 24", amode, 0);
  endtask

  task automatic t_long_load;
    logic [127:0] w = mk_long(4'h5, 2'd2, 2'd1, 4'hA, 0, 1, 0, 1, 64'h1234_5678_9ABC_DEF0);
    load(1, w);
    check("R4 image", psw_out, w);
    check("R4 no err", spec_err, 0);
    check("R11 key", key, 4'h5);
    check("R11 space", addr_space, 2);
    check("R11 io", io_mask, 1);
    check("R11 pm", prog_mask, 4'hA);
    check("R8 mode 64", amode, 2);
    check("R10 long ext", {ext_is_long, ext_word}, {1'b1, w});
  endtask

  task automatic t_branch;
    for (int c = 0; c < 4; c++) begin
      set_en = 1; set_cc = 2'(c); set_pm = 4'h3; tick(); set_en = 0;
      check("R7 cc written", cc, c);
      for (int m = 0; m < 16; m++) begin
        br_mask = 4'(m); #1;
        check("R2 branch", br_taken, (m >> (3 - c)) & 1);
      end
    end
    br_mask = 0;
  endtask

  task automatic t_wrap;
    load(1, mk_long(0, 0, 0, 0, 0, 1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFE));
    advance(3);
    check("R9 wrap 64", instr_addr, 64'h4);
    advance(0);
    check("R9 len 0", instr_addr, 64'h4);
    load(0, mk_short(4'h2, 2'd3, 1, 31'h7FFF_FFFC));
    check("R3 short image", psw_out, mk_long(4'h2, 0, 2'd3, 0, 0, 0, 1, 0, 64'h7FFF_FFFC));
    check("R8 mode 31", amode, 1);
    advance(3);
    check("R9 wrap 31", instr_addr, 64'h2);
    check("R10 short ext", {ext_is_long, ext_word}, {1'b0, mk_short(4'h2, 2'd3, 1, 31'h2)});
    load(0, mk_short(0, 0, 0, 31'h00FF_FFFE));
    advance(1);
    check("R9 wrap 24", instr_addr, 64'h0);
  endtask

  task automatic t_spec;
    logic [127:0] base = mk_long(4'h7, 2'd1, 2'd2, 4'h1, 0, 0, 1, 0, 64'h40);
    logic [127:0] bad [5];
    bad[0] = base; bad[0][127-12] = 1'b1;
    bad[1] = base; bad[1][127-26] = 1'b1;
    bad[2] = base; bad[2][127-40] = 1'b1;
    bad[3] = mk_short(1, 1, 0, 31'h10); bad[3][127-12] = 1'b0;
    bad[4] = base; bad[4][127-31] = 1'b1;
    load(1, base);
    for (int i = 0; i < 5; i++) begin
      load(i != 3, bad[i]);
      check("R5 spec pulse", {spec_err, priv_err}, 2'b10);
      check("R5 unchanged", psw_out, base);
      tick();
      check("R5 pulse ends", spec_err, 0);
    end
  endtask

  task automatic t_set_scope;
    logic [127:0] base = mk_long(4'h9, 2'd3, 2'd0, 4'h0, 0, 0, 1, 1, 64'h100);
    logic [127:0] exp, other;
    load(1, base);
    set_en = 1; set_cc = 2; set_pm = 4'hC; tick(); set_en = 0;
    exp = base; exp[127-18 -: 2] = 2; exp[127-20 -: 4] = 4'hC;
    check("R7 only cc pm", psw_out, exp);
    other = mk_long(4'h1, 0, 2'd1, 4'h6, 0, 0, 0, 0, 64'h20);
    set_en = 1; set_cc = 3; set_pm = 4'hF; adv_en = 1; adv_len = 2;
    load(1, other);
    set_en = 0; adv_en = 0;
    check("R7 load wins", psw_out, other);
  endtask

  task automatic t_priv;
    logic [127:0] p = mk_long(4'h3, 0, 2'd1, 4'h0, 1, 0, 0, 0, 64'h80);
    logic [127:0] bad;
    load(1, p);
    check("R6 problem set", problem_st, 1);
    load(1, mk_long(0, 0, 0, 0, 0, 0, 0, 0, 64'h0));
    check("R6 priv pulse", {spec_err, priv_err}, 2'b01);
    check("R6 unchanged", psw_out, p);
    bad = p; bad[127-12] = 1'b1;
    load(1, bad);
    check("R6 priv before spec", {spec_err, priv_err}, 2'b01);
    set_en = 1; set_cc = 3; set_pm = 4'h5; tick(); set_en = 0;
    check("R7 set in problem", {cc, prog_mask}, {2'd3, 4'h5});
    do_reset();
    check("R1 after reset", psw_out, '0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_long_load();
    t_branch();
    t_wrap();
    t_spec();
    t_set_scope();
    t_priv();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule